// File: doc/BRIEF.md
# Dual-Mode Oscillator Lock Supervisor

This block sequences the coarse calibration and the lock monitoring of a frequency synthesizer whose oscillator has a switched capacitor bank. Out of reset it asks the coarse calibrator to start, while the detector mode is set to analog, which uses the window comparator on the tuning voltage. When the calibrator reports that it has finished, the supervisor allows a fixed settling time for fine locking. It then qualifies lock from the analog window indicator, which must read "in window" for a programmable run of consecutive reference cycles.

After lock is declared the supervisor raises its lock flag and moves the detector to the digital mode, in which a frequency counter issues periodic verdicts. A counter verdict of "in range" clears the tally of unlock verdicts. Three unlock verdicts in a row drop the lock flag, send a fresh start pulse to the calibrator and return the detector to analog mode, all in the same cycle. The calibrator, the frequency counter and the analog comparator are outside this block and appear only as inputs.

Top module: `lock_supervisor`

## Requirements
- R1: While `rst_n` is low, `locked`, `cal_start` and `mode_dig` are 0. At the first clock edge after reset is released, `cal_start` pulses with `mode_dig` = 0.
- R2: `cal_start` is never high for two cycles in a row.
- R3: After the edge that samples `cal_done` high during calibration, the supervisor spends `FINE_WAIT` cycles in fine locking, and `ana_ind` has no effect during those cycles.
- R4: In lock detection, lock is declared at the edge that samples the `qual_len`-th consecutive `ana_ind` = 2'b00. A `qual_len` of 0 behaves as 1. With no glitch, `locked` rises at edge `cal_done` edge + `FINE_WAIT` + `qual_len`.
- R5: Any `ana_ind` value other than 2'b00 during lock detection restarts the qualification run from zero.
- R6: `mode_dig` is 1 exactly while the supervisor is in unlock detection, that is, while `locked` is 1. It is 0 during calibration, fine locking and lock detection.
- R7: In unlock detection, a `dig_valid` strobe with `dig_ind` != 2'b00 is an unlock verdict. A strobe with `dig_ind` = 2'b00 is a locked verdict and clears the tally of consecutive unlock verdicts.
- R8: The third consecutive unlock verdict drops `locked` to 0, pulses `cal_start` and sets `mode_dig` to 0 at the same edge. The supervisor then waits again for `cal_done`.
- R9: `dig_valid` strobes outside unlock detection have no effect. This includes a strobe at the edge where lock is declared, and none of these strobes count toward the tally.
- R10: The state register (reset, calibrate, fine lock, lock detect, unlock detect) is one-hot at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_done | input | 1 | Coarse calibrator finished |
| ana_ind | input | 2 | Analog window indicator, 2'b00 = in window |
| dig_valid | input | 1 | Frequency counter verdict strobe |
| dig_ind | input | 2 | Counter verdict, 2'b00 = in range, other = off |
| qual_len | input | QUAL_W | Lock qualification length in reference cycles |
| cal_start | output | 1 | One-cycle start pulse to the calibrator |
| mode_dig | output | 1 | Detector mode select: 0 analog, 1 digital |
| locked | output | 1 | Lock flag |

## Verification
The sharpest collision is between the last qualifying analog cycle and a digital unlock strobe arriving at the same edge. The bench raises `dig_valid` with an off-range verdict exactly on the edge where lock is declared, for one value of `qual_len`. It then requires that two further unlock verdicts still leave `locked` high, which shows that the coincident strobe was not counted. A second collision is tested by pulsing the analog indicator out of window on the last cycle of fine locking. The bench requires that the lock edge arrives exactly on the arithmetic schedule, unchanged by that pulse.

// File: rtl/lksup_pkg.sv
package lksup_pkg;
    typedef enum logic [4:0] {
        ST_RESET = 5'b00001,
        ST_CAL   = 5'b00010,
        ST_FINE  = 5'b00100,
        ST_LDET  = 5'b01000,
        ST_UDET  = 5'b10000
    } sup_state_e;

    localparam logic [1:0] IND_OK = 2'b00;
endpackage

// File: rtl/lksup_qual.sv
module lksup_qual #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         hit,
    input  logic [W-1:0] len,
    output logic         reached
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en || !hit)
            cnt_d = '0;
        else if (cnt_q == {W{1'b1}})
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign reached = en && hit && (({1'b0, cnt_q} + 1'b1) >= {1'b0, len});

    // R5
    restart_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hit) |=> (cnt_q == '0));
endmodule

// File: rtl/lksup_tally.sv
module lksup_tally #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic valid,
    input  logic bad,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign trip = en && valid && bad && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!en || trip)
            cnt_d = '0;
        else if (valid)
            cnt_d = bad ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7
    good_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && valid && !bad) |=> (cnt_q == '0));
endmodule

// File: rtl/lock_supervisor.sv
module lock_supervisor
    import lksup_pkg::*;
#(
    parameter int FINE_WAIT  = 16,
    parameter int QUAL_W     = 8,
    parameter int MISS_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_done,
    input  logic [1:0]        ana_ind,
    input  logic              dig_valid,
    input  logic [1:0]        dig_ind,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              cal_start,
    output logic              mode_dig,
    output logic              locked
);
    localparam int FW = $clog2(FINE_WAIT + 1);
    localparam logic [FW-1:0] FINE_LAST = FW'(FINE_WAIT - 1);

    typedef struct packed {
        sup_state_e    state;
        logic [FW-1:0] fine_cnt;
        logic          cal_start;
        logic          mode_dig;
        logic          locked;
    } sup_regs_t;

    sup_regs_t cur_q, nxt_d;
    logic      qual_hit;
    logic      miss_trip;

    lksup_qual #(.W(QUAL_W)) qual_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cur_q.state == ST_LDET),
        .hit     (ana_ind == IND_OK),
        .len     (qual_len),
        .reached (qual_hit)
    );

    lksup_tally #(.LIMIT(MISS_LIMIT)) tally_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cur_q.state == ST_UDET),
        .valid (dig_valid),
        .bad   (dig_ind != IND_OK),
        .trip  (miss_trip)
    );

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.cal_start = 1'b0;
        unique case (cur_q.state)
            ST_RESET: begin
                nxt_d.state     = ST_CAL;
                nxt_d.cal_start = 1'b1;
                nxt_d.locked    = 1'b0;
                nxt_d.mode_dig  = 1'b0;
            end
            ST_CAL: begin
                if (cal_done) begin
                    nxt_d.state    = ST_FINE;
                    nxt_d.fine_cnt = '0;
                end
            end
            ST_FINE: begin
                if (cur_q.fine_cnt == FINE_LAST)
                    nxt_d.state = ST_LDET;
                else
                    nxt_d.fine_cnt = cur_q.fine_cnt + 1'b1;
            end
            ST_LDET: begin
                if (qual_hit) begin
                    nxt_d.state    = ST_UDET;
                    nxt_d.locked   = 1'b1;
                    nxt_d.mode_dig = 1'b1;
                end
            end
            ST_UDET: begin
                if (miss_trip) begin
                    nxt_d.state     = ST_CAL;
                    nxt_d.locked    = 1'b0;
                    nxt_d.mode_dig  = 1'b0;
                    nxt_d.cal_start = 1'b1;
                end
            end
            default: nxt_d.state = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state     <= ST_RESET;
            cur_q.fine_cnt  <= '0;
            cur_q.cal_start <= 1'b0;
            cur_q.mode_dig  <= 1'b0;
            cur_q.locked    <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cal_start = cur_q.cal_start;
    assign mode_dig  = cur_q.mode_dig;
    assign locked    = cur_q.locked;

    // R10
    state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cur_q.state));

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R8
    drop_starts_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> (cal_start && !mode_dig));

    // R6
    locked_in_udet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked == mode_dig) && (locked == (cur_q.state == ST_UDET)));
endmodule

// File: tb/lock_supervisor_tb.sv
module lock_supervisor_tb_top;
    localparam int FW = 4;
    localparam int QW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cal_done;
    logic [1:0]    ana_ind;
    logic          dig_valid;
    logic [1:0]    dig_ind;
    logic [QW-1:0] qual_len;
    logic          cal_start, mode_dig, locked;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    lock_supervisor #(.FINE_WAIT(FW), .QUAL_W(QW), .MISS_LIMIT(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .ana_ind(ana_ind),
        .dig_valid(dig_valid), .dig_ind(dig_ind), .qual_len(qual_len),
        .cal_start(cal_start), .mode_dig(mode_dig), .locked(locked)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // drive one counter verdict for one edge, then check the outputs
    task automatic verdict(input bit off, input int exp_lock, input int exp_start);
        dig_valid = 1'b1;
        dig_ind   = off ? 2'b01 : 2'b00;
        tick();
        dig_valid = 1'b0;
        dig_ind   = 2'b00;
        check("R7 locked after verdict", locked, exp_lock);
        check("R8 cal_start after verdict", cal_start, exp_start);
        check("R6 mode after verdict", mode_dig, exp_lock);
    endtask

    // from CALIBRATE: give cal_done and follow the lock schedule
    task automatic do_lock(input int q, input int g, input bit fine_glitch, input bit coinc);
        int qe;
        int last;
        qe = (q == 0) ? 1 : q;
        last = FW + qe + g;
        qual_len = QW'(q);
        cal_done = 1'b1;
        ana_ind  = 2'b00;
        tick();
        cal_done = 1'b0;
        for (int i = 1; i <= last; i++) begin
            ana_ind = 2'b00;
            if (fine_glitch && i == FW) ana_ind = 2'b10;   // R3: ignored
            if (g > 0 && i == FW + g)   ana_ind = 2'b01;   // R5: restart
            if (coinc && i == last) begin
                dig_valid = 1'b1;
                dig_ind   = 2'b10;                         // R9: ignored
            end
            tick();
            dig_valid = 1'b0;
            dig_ind   = 2'b00;
            if (i == last - 1) begin
                check("R4 not locked one edge early", locked, 0);
                check("R6 analog before lock", mode_dig, 0);
            end
            if (i == last) begin
                check("R4 locked on schedule", locked, 1);
                check("R6 digital once locked", mode_dig, 1);
            end
        end
        ana_ind = 2'b00;
    endtask

    initial begin
        rst_n = 1'b0; cal_done = 1'b0; ana_ind = 2'b00;
        dig_valid = 1'b0; dig_ind = 2'b00; qual_len = '0;
        repeat (3) tick();
        check("R1 reset locked", locked, 0);
        check("R1 reset cal_start", cal_start, 0);
        check("R1 reset mode", mode_dig, 0);
        rst_n = 1'b1;
        tick();
        check("R1 start pulse after reset", cal_start, 1);
        check("R1 analog mode after reset", mode_dig, 0);
        tick();
        check("R2 start pulse one cycle", cal_start, 0);

        // R9: verdicts during calibration do nothing
        for (int k = 0; k < 4; k++) verdict(1'b1, 0, 0);

        for (int q = 0; q <= 7; q++) begin
            int qe;
            int g;
            qe = (q == 0) ? 1 : q;
            g  = (qe > 1) ? qe - 1 : 0;
            do_lock(q, g, q[0], q == 3);
            // R7: tally cleared by a locked verdict; R9 coincident strobe ignored
            verdict(1'b1, 1, 0);
            verdict(1'b1, 1, 0);
            verdict(1'b0, 1, 0);
            verdict(1'b1, 1, 0);
            verdict(1'b1, 1, 0);
            verdict(1'b1, 0, 1);   // R8: third in a row restarts
            check("R8 analog mode after restart", mode_dig, 0);
            tick();
            check("R2 restart pulse one cycle", cal_start, 0);
            check("R8 waits for cal_done", locked, 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule